// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits between the register-file port of a small 8-bit processor and a byte-wide synchronous data memory. On a start strobe it takes an operation code, a 16-bit pointer and one register byte. It then performs a single indivisible access on the addressed byte: one read cycle followed directly by one write cycle. The register always gets back the byte that memory held before the access. Memory receives one of four results: the register byte itself (swap), the OR of both bytes (set bits), the old byte with the register's 1-bits cleared (clear bits), or the XOR of both bytes (flip bits).

Bit modification only takes effect inside a parameterised plain-RAM address window. Pointers outside that window are treated as memory-mapped register space, and every operation there degrades to a plain swap. A lock output covers the whole access, so a bus arbiter can keep other masters off the byte between the read and the write. A typical use is a semaphore or flag word shared with an interrupt handler or a second bus master.

Top module: `atomic_rmw_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, all of the following are low: mem_re_o, mem_we_o, done_o, reg_we_o, lock_o, reg_wdata_o, mem_wdata_o and mem_addr_o.
- R2: A start accepted at a clock edge makes the next cycle a read cycle (mem_re_o high, mem_addr_o equal to the pointer). The cycle after that is a write cycle, in which mem_we_o, done_o and reg_we_o are all high. The unit is idle in the cycle that follows.
- R3: In the write cycle, reg_wdata_o equals the memory byte as it was before the operation, for every op_i value.
- R4: op_i = 2'b00 (swap) writes reg_val_i to memory unchanged.
- R5: op_i = 2'b01 writes reg_val_i | old byte when the pointer is in the RAM window.
- R6: op_i = 2'b10 writes old byte & ~reg_val_i when the pointer is in the RAM window.
- R7: op_i = 2'b11 writes reg_val_i ^ old byte when the pointer is in the RAM window.
- R8: The RAM window covers RAM_BASE to RAM_LIMIT inclusive (default 0x2000 to 0x3FFF). For any other pointer, op_i values 01, 10 and 11 write reg_val_i unchanged, exactly as swap does.
- R9: lock_o is high from the cycle after the accepted strobe through the done cycle, and low whenever the unit is idle.
- R10: A start strobe that arrives during the read or write cycle is ignored: it causes no further read or write, and the unit returns to idle after the done cycle.
- R11: mem_addr_o is the same in the read and write cycles, and the write always directly follows the read, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| op_i | input | 2 | Operation: 00 swap, 01 set, 10 clear, 11 flip |
| addr_i | input | 16 | Byte pointer |
| reg_val_i | input | 8 | Register operand |
| reg_wdata_o | output | 8 | Old memory byte returned to the register |
| reg_we_o | output | 1 | Register write enable |
| done_o | output | 1 | Completion pulse |
| lock_o | output | 1 | Bus lock for the arbiter |
| mem_addr_o | output | 16 | Memory address |
| mem_re_o | output | 1 | Memory read enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after mem_re_o |

## Verification
The strobe is driven on a falling edge and sampled at the next rising edge. The read cycle is therefore checked on the first falling edge after that rising edge, the write cycle together with done_o, reg_we_o and both data values on the second, and the return to idle on the third. Expected write data comes from a bench function of the operation, the pointer's region and a shadow copy of memory. The window limits, the bytes just outside them, and strobes held high during a busy access are all exercised as directed cases, in addition to seeded random operations.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  typedef enum logic [1:0] {
    OP_SWAP  = 2'b00,
    OP_SET   = 2'b01,
    OP_CLR   = 2'b10,
    OP_FLIP  = 2'b11
  } rmw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } rmw_state_e;
endpackage

// File: rtl/rmw_region_decode.sv
module rmw_region_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BASE  = 'h2000,
  parameter int unsigned RAM_LIMIT = 'h3FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_ram_o
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(RAM_LIMIT);

  logic above_base;
  generate
    if (RAM_BASE == 0) begin : g_base_zero
      assign above_base = 1'b1;
    end else begin : g_base_cmp
      assign above_base = (addr_i >= BASE_A);
    end
  endgenerate

  assign in_ram_o = above_base && (addr_i <= LIMIT_A);
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  rmw_op_e           op_i,
  input  logic              in_ram_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o
);
  always_comb begin
    result_o = operand_i;
    if (in_ram_i) begin
      unique case (op_i)
        OP_SET:  result_o = old_i | operand_i;
        OP_CLR:  result_o = old_i & ~operand_i;
        OP_FLIP: result_o = old_i ^ operand_i;
        default: result_o = operand_i;
      endcase
    end
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import atomic_rmw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  rmw_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] val_i,
  output rmw_state_e        state_o,
  output rmw_op_e           op_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] val_q_o
);
  rmw_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q_o   <= OP_SWAP;
      addr_q_o <= '0;
      val_q_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_READ;
          op_q_o   <= op_i;
          addr_q_o <= addr_i;
          val_q_o  <= val_i;
        end
        ST_READ:  state_q <= ST_WRITE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;

  // Operands frozen while busy: a late strobe must not disturb them
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(addr_q_o) && $stable(val_q_o) && $stable(op_q_o));
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RAM_BASE  = 'h2000,
  parameter int unsigned RAM_LIMIT = 'h3FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] reg_val_i,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              done_o,
  output logic              lock_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  rmw_state_e        state;
  rmw_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] val_q;
  logic              in_ram;
  logic [DATA_W-1:0] alu_res;
  logic              wr_cyc;

  rmw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (rmw_op_e'(op_i)),
    .addr_i   (addr_i),
    .val_i    (reg_val_i),
    .state_o  (state),
    .op_q_o   (op_q),
    .addr_q_o (addr_q),
    .val_q_o  (val_q)
  );

  rmw_region_decode #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_LIMIT(RAM_LIMIT)) u_region (
    .addr_i   (addr_q),
    .in_ram_o (in_ram)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i      (op_q),
    .in_ram_i  (in_ram),
    .old_i     (mem_rdata_i),
    .operand_i (val_q),
    .result_o  (alu_res)
  );

  assign wr_cyc      = (state == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_re_o    = (state == ST_READ);
  assign mem_we_o    = wr_cyc;
  assign mem_wdata_o = wr_cyc ? alu_res : '0;
  assign reg_we_o    = wr_cyc;
  assign reg_wdata_o = wr_cyc ? mem_rdata_i : '0;
  assign done_o      = wr_cyc;
  assign lock_o      = (state != ST_IDLE);

  assert_read_then_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o && $stable(mem_addr_o));
  assert_write_after_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));
  assert_done_with_reg_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> reg_we_o && mem_we_o);
  assert_lock_covers_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |-> lock_o);
  assert_single_access_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_re_o, mem_we_o}));
  assert_done_releases_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !lock_o && !mem_re_o);
  assert_io_swap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !in_ram) |-> (mem_wdata_o == val_q));
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] addr = '0;
  logic [7:0]  rval = '0;
  logic [7:0]  reg_wdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic        reg_we, done, lock, mem_re, mem_we;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [7:0] mem    [256];
  logic [7:0] shadow [256];

  always #4 clk = ~clk;

  atomic_rmw_unit u_atomic_rmw_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .reg_val_i(rval), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .done_o(done),
    .lock_o(lock), .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // Synchronous byte memory (low address byte selects the entry)
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_write(input logic [1:0] o, input logic [15:0] a,
                                           input logic [7:0] v, input logic [7:0] old);
    bit ram = (a >= 16'h2000) && (a <= 16'h3FFF);
    if (!ram) return v;
    case (o)
      2'b01:   return old | v;
      2'b10:   return old & ~v;
      2'b11:   return old ^ v;
      default: return v;
    endcase
  endfunction

  // Issue one operation; busy_poke drives a second strobe while busy (R10)
  task automatic do_op(input logic [1:0] o, input logic [15:0] a, input logic [7:0] v,
                       input bit busy_poke);
    logic [7:0] old = shadow[a[7:0]];
    logic [7:0] ew  = exp_write(o, a, v, old);
    @(negedge clk);
    start = 1'b1; op = o; addr = a; rval = v;
    @(negedge clk);
    if (busy_poke) begin
      op = ~o; addr = a ^ 16'h0001; rval = ~v;
    end else start = 1'b0;
    chk(mem_re && !mem_we && !done, "R2 read cycle", {mem_re, mem_we, done}, 3'b100);
    chk(mem_addr == a, "R11 read address", mem_addr, a);
    chk(lock, "R9 lock in read", lock, 1);
    @(negedge clk);
    start = 1'b0;
    chk(mem_we && done && reg_we && !mem_re, "R2 write cycle",
        {mem_we, done, reg_we, mem_re}, 4'b1110);
    chk(mem_addr == a, "R11 write address", mem_addr, a);
    chk(reg_wdata == old, "R3 old byte to register", reg_wdata, old);
    case (o)
      2'b00:   chk(mem_wdata == ew, "R4 swap data", mem_wdata, ew);
      2'b01:   chk(mem_wdata == ew, "R5/R8 set data", mem_wdata, ew);
      2'b10:   chk(mem_wdata == ew, "R6/R8 clear data", mem_wdata, ew);
      default: chk(mem_wdata == ew, "R7/R8 flip data", mem_wdata, ew);
    endcase
    chk(lock, "R9 lock in done", lock, 1);
    shadow[a[7:0]] = ew;
    @(negedge clk);
    chk(!lock && !mem_re && !mem_we && !done, "R10 idle after done",
        {lock, mem_re, mem_we, done}, 0);
    chk(mem[a[7:0]] == ew, "R2 memory updated", mem[a[7:0]], ew);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk({mem_re, mem_we, done, reg_we, lock} == 0 && reg_wdata == 0 && mem_wdata == 0
        && mem_addr == 0, "R1 reset outputs", {mem_re, mem_we, done, reg_we, lock}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_re, mem_we, done, reg_we, lock} == 0, "R1 after release",
        {mem_re, mem_we, done, reg_we, lock}, 0);

    // Directed: window edges, each op in and out of the RAM window
    do_op(2'b00, 16'h2000, 8'hA5, 0);
    do_op(2'b01, 16'h2000, 8'h0F, 0);
    do_op(2'b10, 16'h3FFF, 8'hF0, 0);
    do_op(2'b11, 16'h3FFF, 8'h3C, 0);
    do_op(2'b01, 16'h1FFF, 8'h81, 0);
    do_op(2'b10, 16'h4000, 8'hFF, 0);
    do_op(2'b11, 16'h0040, 8'h55, 0);
    do_op(2'b01, 16'hFFFF, 8'h00, 0);
    do_op(2'b10, 16'h2A10, 8'h00, 0);
    do_op(2'b01, 16'h2A10, 8'hFF, 0);
    // Strobe held during the busy cycles
    do_op(2'b11, 16'h2100, 8'h77, 1);
    do_op(2'b00, 16'h0100, 8'h12, 1);

    for (int k = 0; k < 300; k++) begin
      logic [15:0] a;
      int sel = $urandom_range(0, 5);
      case (sel)
        0: a = 16'h2000;
        1: a = 16'h3FFF;
        2: a = 16'h1FFF;
        3: a = 16'h4000;
        default: a = 16'($urandom());
      endcase
      do_op(2'($urandom()), a, 8'($urandom()), ($urandom_range(0, 7) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule